// File: doc/BRIEF.md
# Network Interrupt Moderation Controller

This block sits between the receive and transmit paths of a network controller and the CPU interrupt line. It collects interrupt causes into a pending register, gates them with a mask register, and paces the line with a throttling timer, so a busy link does not flood the processor with interrupts.

It also runs four delay timers: a per-packet timer and an absolute timer for each direction. When any of them runs out, the block asks the descriptor engine to write back every used descriptor (a zero alignment mask) and posts that direction's cause with the immediate flag, so the throttle does not hold it back. All timers count in units of a base tick. With the default divider of 205 clocks at 200 MHz, one tick is about 1024 ns.

Top module: `irq_moderator`

## Requirements
- R1: After reset, `irq`, `pend_q`, `rx_wb_req` and `tx_wb_req` are all zero, the mask is zero and every timer value is zero.
- R2: A cycle with bit k of `cause_pulse` high sets bit k of `pend_q` at the next edge. `irq` is high whenever (pending AND mask) is non-zero, subject to the throttle rule of R4.
- R3: A post with `cause_now` high, or a post from an expiring delay timer, raises `irq` at the next edge even while the throttle window is open, provided the posted cause is unmasked.
- R4: A rising edge of `irq` loads the throttle window (timer slot 4) in ticks. While the window is non-zero, a post without the immediate flag does not raise `irq`. The line rises once the window has drained if the cause is still pending and unmasked. A throttle value of zero disables throttling.
- R5: A mask write (`mask_wr`) takes effect at the next edge. It drops `irq` when no pending cause remains unmasked, and it raises `irq` when a pending cause becomes unmasked.
- R6: `pend_rd` clears the pending register and drops `irq` at the next edge. A cause posted in the same cycle survives the clear.
- R7: Receive timers are slot 0 (per packet) and slot 1 (absolute), both armed by `rx_pkt`. On expiry, `rx_wb_req` pulses for one cycle, and pending bit 1 (receive-timer cause) is posted with the immediate flag.
- R8: Transmit timers are slot 2 (per packet) and slot 3 (absolute), both armed by `tx_pkt`. On expiry, `tx_wb_req` pulses for one cycle, and pending bit 0 (transmit-written-back cause) is posted with the immediate flag.
- R9: A `wb_done` strobe posts pending bit 0 without the immediate flag and raises no writeback request.
- R10: A per-packet timer restarts from its programmed value on every arming event. An absolute timer ignores arming while it is running.
- R11: A timer whose programmed value is zero never expires and is stopped.
- R12: A timer programmed to N expires between 4(N-1)+1 and 4N edges after the arming edge when TICK_DIV is 4, that is, after N ticks of TICK_DIV clocks each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_pulse | input | NCAUSE | One-cycle cause posts from the data paths |
| cause_now | input | 1 | Immediate flag for the posts in this cycle |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | NCAUSE | New mask value |
| pend_rd | input | 1 | Read-to-clear of the pending register |
| pend_q | output | NCAUSE | Pending cause register |
| timer_wr | input | 1 | Timer value write strobe |
| timer_sel | input | 3 | Timer slot: 0 rx packet, 1 rx absolute, 2 tx packet, 3 tx absolute, 4 throttle |
| timer_wdata | input | TW | Timer value in ticks |
| rx_pkt | input | 1 | Receive event that arms the receive timers |
| tx_pkt | input | 1 | Transmit event that arms the transmit timers |
| wb_done | input | 1 | Transmit descriptor writeback completed |
| irq | output | 1 | CPU interrupt line |
| rx_wb_req | output | 1 | Full receive descriptor writeback request |
| tx_wb_req | output | 1 | Full transmit descriptor writeback request |

## Verification
The assertions assume that every strobe input lasts one clock cycle, that `cause_pulse` has no bit set at indices the mask does not cover, and that timer values change only through `timer_wr`. The stimulus drives each strobe for exactly one cycle between falling edges. It never writes slots above 4. It spaces packet events so that per-packet and absolute expiries land in separate, predictable windows. The throttle property assumes that no immediate post arrives in the same cycle, which is why the immediate case is driven on its own.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  localparam int CAUSE_TXWB = 0;
  localparam int CAUSE_RXTMR = 1;
  localparam int NUM_DELAY = 4;
  localparam int SLOT_THROTTLE = 4;
  localparam int NUM_SLOTS = NUM_DELAY + 1;

  // receive timers occupy the two low slots, the even slot restarts per event
  function automatic bit slot_is_rx(int slot);
    return slot < 2;
  endfunction

  function automatic bit slot_restarts(int slot);
    return (slot % 2) == 0;
  endfunction
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int TICK_DIV = 205
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;
  logic wrap;

  assign wrap = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= wrap;
      div_q <= wrap ? '0 : div_q + 1'b1;
    end
  end

  a_r12_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int TW = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          arm,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt_q;
  logic          run_q;
  logic          take_arm;

  assign take_arm = arm && (RESTART || !run_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load_val == '0) begin
        run_q <= 1'b0;
      end else if (take_arm) begin
        cnt_q <= load_val;
        run_q <= 1'b1;
      end else if (tick && run_q) begin
        if (cnt_q == TW'(1)) begin
          run_q  <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  a_r11_zero_never_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (load_val == '0) |=> !expire);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          want,
  input  logic          now,
  input  logic [TW-1:0] interval,
  output logic          irq
);
  logic [TW-1:0] win_q;
  logic          irq_d;
  logic          rise;

  function automatic logic may_raise(logic held, logic urgent,
                                     logic [TW-1:0] ival, logic [TW-1:0] left);
    return held || urgent || (ival == '0) || (left == '0);
  endfunction

  assign irq_d = want && may_raise(irq, now, interval, win_q);
  assign rise  = irq_d && !irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      win_q <= '0;
    end else begin
      irq <= irq_d;
      if (rise) win_q <= interval;
      else if (tick && win_q != '0) win_q <= win_q - 1'b1;
    end
  end

  a_r4_hold_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && win_q != '0 && interval != '0 && !now) |=> !irq);
  a_r3_urgent_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (want && now) |=> irq);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int NCAUSE = 8,
  parameter int TW = 16,
  parameter int TICK_DIV = 205
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] cause_pulse,
  input  logic              cause_now,
  input  logic              mask_wr,
  input  logic [NCAUSE-1:0] mask_wdata,
  input  logic              pend_rd,
  output logic [NCAUSE-1:0] pend_q,
  input  logic              timer_wr,
  input  logic [2:0]        timer_sel,
  input  logic [TW-1:0]     timer_wdata,
  input  logic              rx_pkt,
  input  logic              tx_pkt,
  input  logic              wb_done,
  output logic              irq,
  output logic              rx_wb_req,
  output logic              tx_wb_req
);
  logic [TW-1:0]     tval [NUM_SLOTS];
  logic [NUM_DELAY-1:0] tmr_exp;
  logic              tick;
  logic [NCAUSE-1:0] mask_q;
  logic [NCAUSE-1:0] post_vec;
  logic [NCAUSE-1:0] pend_d;
  logic [NCAUSE-1:0] mask_d;
  logic              post_now;
  logic              want;

  function automatic logic [NCAUSE-1:0] merge_causes(logic [NCAUSE-1:0] ext,
                                                     logic rx_hit, logic tx_hit);
    logic [NCAUSE-1:0] v;
    v = ext;
    if (rx_hit) v[CAUSE_RXTMR] = 1'b1;
    if (tx_hit) v[CAUSE_TXWB] = 1'b1;
    return v;
  endfunction

  irq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SLOTS; k++) tval[k] <= '0;
    end else if (timer_wr) begin
      for (int k = 0; k < NUM_SLOTS; k++)
        if (timer_sel == 3'(k)) tval[k] <= timer_wdata;
    end
  end

  for (genvar t = 0; t < NUM_DELAY; t++) begin : g_tmr
    irq_delay_timer #(.TW(TW), .RESTART(slot_restarts(t))) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .arm(slot_is_rx(t) ? rx_pkt : tx_pkt),
      .load_val(tval[t]),
      .expire(tmr_exp[t]));
  end

  assign rx_wb_req = tmr_exp[0] | tmr_exp[1];
  assign tx_wb_req = tmr_exp[2] | tmr_exp[3];

  assign post_vec = merge_causes(cause_pulse, rx_wb_req, tx_wb_req | wb_done);
  assign post_now = (cause_now && cause_pulse != '0) || rx_wb_req || tx_wb_req;
  assign pend_d   = (pend_rd ? '0 : pend_q) | post_vec;
  assign mask_d   = mask_wr ? mask_wdata : mask_q;
  assign want     = (pend_d & mask_d) != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  irq_throttle #(.TW(TW)) u_thr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .want(want), .now(post_now),
    .interval(tval[SLOT_THROTTLE]), .irq(irq));

  a_r2_line_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_q & mask_q) != '0));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd && post_vec == '0) |=> (pend_q == '0 && !irq));
  a_r7_rx_posts: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_req |=> pend_q[CAUSE_RXTMR]);
  a_r8_tx_posts: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wb_req && !mask_wr && mask_q[CAUSE_TXWB]) |=> irq);
  a_r9_wb_done_posts: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> pend_q[CAUSE_TXWB]);
  a_r5_mask_off_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_wdata == '0) |=> !irq);
endmodule

// File: tb/sim_irq_moderator.sv
module sim_irq_moderator;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cause_pulse = '0, mask_wdata = '0, pend_q;
  logic cause_now = 0, mask_wr = 0, pend_rd = 0, timer_wr = 0;
  logic [2:0] timer_sel = '0;
  logic [15:0] timer_wdata = '0;
  logic rx_pkt = 0, tx_pkt = 0, wb_done = 0, irq, rx_wb_req, tx_wb_req;

  int n_chk = 0, n_fail = 0, rx_seen = 0, tx_seen = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  irq_moderator #(.NCAUSE(8), .TW(16), .TICK_DIV(DIV)) u0 (.*);

  // behavioural reference
  int m_div = 0, m_win = 0;
  int m_cnt[4], m_val[5];
  bit m_tick = 0, m_irq = 0;
  bit m_act[4], m_exp[4];
  bit [7:0] m_pend = 0, m_mask = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_win = 0; m_tick = 0; m_irq = 0; m_pend = 0; m_mask = 0;
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_act[i] = 0; m_exp[i] = 0; end
      for (int i = 0; i < 5; i++) m_val[i] = 0;
    end else begin
      bit rxe, txe, nowf, want, nirq;
      bit [7:0] post, np, nm;
      rxe = m_exp[0] | m_exp[1];
      txe = m_exp[2] | m_exp[3];
      post = cause_pulse;
      if (rxe) post[1] = 1;
      if (txe || wb_done) post[0] = 1;
      nowf = (cause_now && cause_pulse != 0) || rxe || txe;
      np = (pend_rd ? 8'h00 : m_pend) | post;
      nm = mask_wr ? mask_wdata : m_mask;
      want = (np & nm) != 0;
      nirq = want && (m_irq || nowf || m_val[4] == 0 || m_win == 0);
      if (nirq && !m_irq) m_win = m_val[4];
      else if (m_tick && m_win > 0) m_win--;
      m_irq = nirq; m_pend = np; m_mask = nm;
      for (int t = 0; t < 4; t++) begin
        bit arm;
        arm = (t < 2) ? rx_pkt : tx_pkt;
        m_exp[t] = 0;
        if (m_val[t] == 0) m_act[t] = 0;
        else if (arm && (t % 2 == 0 || !m_act[t])) begin m_cnt[t] = m_val[t]; m_act[t] = 1; end
        else if (m_tick && m_act[t]) begin
          if (m_cnt[t] == 1) begin m_act[t] = 0; m_exp[t] = 1; end
          else m_cnt[t]--;
        end
      end
      if (timer_wr && timer_sel < 5) m_val[timer_sel] = timer_wdata;
      m_tick = (m_div == DIV - 1);
      m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(irq == m_irq, phase, "irq vs model", int'(irq), int'(m_irq));
    chk(pend_q == m_pend, phase, "pending vs model", int'(pend_q), int'(m_pend));
    chk(rx_wb_req == (m_exp[0] | m_exp[1]), phase, "rx_wb_req vs model", int'(rx_wb_req), int'(m_exp[0] | m_exp[1]));
    chk(tx_wb_req == (m_exp[2] | m_exp[3]), phase, "tx_wb_req vs model", int'(tx_wb_req), int'(m_exp[2] | m_exp[3]));
    if (rx_wb_req) rx_seen++;
    if (tx_wb_req) tx_seen++;
  end

  task automatic step(int n); repeat (n) @(negedge clk); endtask
  task automatic post_c(bit [7:0] c, bit now);
    @(negedge clk); cause_pulse = c; cause_now = now;
    @(negedge clk); cause_pulse = '0; cause_now = 0;
  endtask
  task automatic wr_mask(bit [7:0] m);
    @(negedge clk); mask_wr = 1; mask_wdata = m;
    @(negedge clk); mask_wr = 0;
  endtask
  task automatic wr_tmr(int sel, int v);
    @(negedge clk); timer_wr = 1; timer_sel = 3'(sel); timer_wdata = 16'(v);
    @(negedge clk); timer_wr = 0;
  endtask
  task automatic rd_pend;
    @(negedge clk); pend_rd = 1;
    @(negedge clk); pend_rd = 0;
  endtask
  task automatic rx_ev; @(negedge clk); rx_pkt = 1; @(negedge clk); rx_pkt = 0; endtask
  task automatic tx_ev; @(negedge clk); tx_pkt = 1; @(negedge clk); tx_pkt = 0; endtask
  task automatic wbd; @(negedge clk); wb_done = 1; @(negedge clk); wb_done = 0; endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    step(3); rst_n = 1; step(1);
    chk(irq == 0 && pend_q == 0 && !rx_wb_req && !tx_wb_req, "R1", "reset outputs", int'(irq), 0);

    phase = "R2"; wr_mask(8'hFF); post_c(8'h08, 0);
    chk(irq == 1 && pend_q == 8'h08, "R2", "post raises", int'(pend_q), 8'h08);

    phase = "R6"; rd_pend;
    chk(pend_q == 0 && irq == 0, "R6", "read clears", int'(pend_q), 0);

    phase = "R4"; wr_tmr(4, 3); post_c(8'h10, 0);
    chk(irq == 1, "R4", "first raise open", int'(irq), 1);
    rd_pend; post_c(8'h10, 0);
    chk(irq == 0, "R4", "held in window", int'(irq), 0);
    phase = "R3"; post_c(8'h20, 1);
    chk(irq == 1, "R3", "immediate bypass", int'(irq), 1);
    rd_pend; step(20); phase = "R4"; post_c(8'h04, 0);
    chk(irq == 1, "R4", "raise after window", int'(irq), 1);

    phase = "R5"; wr_tmr(4, 0); wr_mask(8'h00);
    chk(irq == 0, "R5", "mask drop", int'(irq), 0);
    wr_mask(8'hFF);
    chk(irq == 1, "R5", "mask raise", int'(irq), 1);
    rd_pend;

    phase = "R7"; wr_tmr(0, 2); wr_tmr(1, 0); wr_tmr(4, 10);
    post_c(8'h80, 0); rd_pend;
    rx_seen = 0; rx_ev;
    k = 0;
    while (!rx_wb_req && k < 50) begin step(1); k++; end
    chk(k >= 5 && k <= 8, "R12", "expiry delay", k, 8);
    step(3);
    chk(rx_seen == 1, "R7", "rx writeback pulses", rx_seen, 1);
    chk(pend_q[1] == 1 && irq == 1, "R7", "rx cause immediate", int'(pend_q), 2);

    phase = "R8"; rd_pend; wr_tmr(4, 0); wr_tmr(2, 0); wr_tmr(3, 3);
    tx_seen = 0; tx_ev; step(30);
    chk(tx_seen == 1 && pend_q[0] == 1, "R8", "tx writeback and cause", tx_seen, 1);

    phase = "R10"; rd_pend; wr_tmr(0, 4); wr_tmr(1, 5); rx_seen = 0;
    rx_ev; step(4); rx_ev; step(4); rx_ev; step(9);
    chk(rx_seen == 1, "R10", "absolute fires, packet restarted", rx_seen, 1);
    step(30);
    chk(rx_seen == 2, "R10", "packet timer fires last", rx_seen, 2);

    phase = "R11"; rd_pend; wr_tmr(0, 0); wr_tmr(1, 0); rx_seen = 0;
    rx_ev; step(40);
    chk(rx_seen == 0 && pend_q == 0, "R11", "zero timer silent", rx_seen, 0);

    phase = "R9"; tx_seen = 0; wbd; step(1);
    chk(pend_q == 8'h01 && irq == 1 && tx_seen == 0, "R9", "wb_done posts", int'(pend_q), 1);
    rd_pend; step(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule